// File: doc/BRIEF.md
# Receive Statistics Counter Bank

This block holds one event counter for each of thirteen receive-side frame events of an Ethernet MAC. The events are six frame-size buckets, unicast frames, length errors, out-of-range type fields, pause frames, FIFO overflows, VLAN frames and watchdog errors. A classifier upstream drives one strobe per event, and each strobe cycle adds one to its counter. A control field chooses whether counters wrap to zero or hold at their maximum. A self-clearing command clears every counter and every status bit together.

Each counter owns one interrupt status bit. The bit sets when the counter's most significant bit goes from 0 to 1, which is the half-full point. It stays set until software reads that counter with byte lane 0 enabled. A mask register suppresses chosen bits from the single combined interrupt output. Software reaches everything through a plain read/write strobe port that has per-byte enables. Read data is combinational from the address.

A two-state sequencer runs the clear command. In state RUN the counters count and the status bits set and clear. Writing a 1 to the clear bit takes the transition RUN->WIPE. For one cycle in WIPE the clear bit reads back as 1, and at the end of that cycle all counters and status bits are zeroed. The transition WIPE->RUN follows unless the clear bit is written again, which takes the transition WIPE->WIPE.

Top module: `rxs_stat_bank`

## Requirements
- R1: A strobe on ev_strobe[i] in a clock cycle adds one to counter i at that clock edge. After reset every counter reads 0.
- R2: Status bit 11+i sets at the edge where counter i's MSB changes from 0 to 1. Counter index to event: 0 64-octet, 1 65-127, 2 128-255, 3 256-511, 4 512-1023, 5 1024-max, 6 unicast, 7 length error, 8 out-of-range type, 9 pause, 10 FIFO overflow, 11 VLAN, 12 watchdog error (status bit 23).
- R3: A read of counter i with reg_be[0]=1 clears status bit 11+i at that edge. A read with reg_be[0]=0 leaves the bit unchanged.
- R4: When a clearing read and an increment of the same counter fall in one cycle, reg_rdata shows the value before the increment. If that increment raises the MSB, the status bit ends set; otherwise it ends clear.
- R5: With control bit 1 set to 1, a counter at its all-ones value holds there on further strobes.
- R6: With control bit 1 set to 0, a counter at its all-ones value goes to 0 on the next strobe.
- R7: Writing control bit 0 as 1 with reg_be[0]=1 zeroes all counters and status bits after one cycle. Control bit 0 reads 1 during that cycle and 0 afterwards. Strobes in that cycle are dropped.
- R8: The status word reads 0 in bits [31:24] and [10:0]. Writes to it are ignored. Control, mask and status reset to 0.
- R9: irq is the OR of the status bits not blocked by the mask register. A mask bit of 1 blocks the status bit at the same position. Only mask bits [23:11] are stored; the rest read 0.
- R10: Register map (word addresses): 0 control, 1 status, 2 mask, 4+i counter i, with the counter value zero-extended. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_strobe | input | NUM_CNT | One increment strobe per counter |
| reg_addr | input | ADDR_W | Word address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_be | input | 4 | Byte-lane enables |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| irq | output | 1 | Combined unmasked status |

## Verification
Two functions can act on one counter in the same cycle: a clearing read and an increment. The bench provokes this by raising a counter's strobe in the very cycle that reads it with byte lane 0 enabled. It does this once when the increment raises the MSB and once when the MSB is already set. It judges the result by the read data sampled in that cycle, which must be the pre-increment value, and by the status word and counter read afterwards. A second collision is a strobe arriving during the WIPE cycle; the bench checks that the counter still reads zero afterwards.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
    localparam int REG_W      = 32;
    localparam int BE_W       = REG_W / 8;
    localparam int ADR_CTRL   = 0;
    localparam int ADR_STAT   = 1;
    localparam int ADR_MASK   = 2;
    localparam int ADR_CNT0   = 4;
    localparam int CTRL_WIPE  = 0;
    localparam int CTRL_SAT   = 1;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_WIPE = 1'b1
    } wipe_state_e;
endpackage

// File: rtl/rxs_counter.sv
module rxs_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             wipe,
    input  logic             sat,
    output logic [CNT_W-1:0] q,
    output logic             msb_rise
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] d;

    always_comb begin
        d = q;
        if (wipe) begin
            d = '0;
        end else if (inc) begin
            if (sat && (&q)) begin
                d = q;
            end else begin
                d = q + ONE;
            end
        end
    end

    assign msb_rise = !q[CNT_W-1] && d[CNT_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/rxs_ctrl.sv
module rxs_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic wipe_req,
    input  logic sat_wdata,
    output logic wipe,
    output logic sat_mode
);
    import rxs_pkg::*;

    wipe_state_e state_q;
    wipe_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  state_d = (ctrl_wr && wipe_req) ? ST_WIPE : ST_RUN;
            ST_WIPE: state_d = (ctrl_wr && wipe_req) ? ST_WIPE : ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        wipe = 1'b0;
        unique case (state_q)
            ST_RUN:  wipe = 1'b0;
            ST_WIPE: wipe = 1'b1;
            default: wipe = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sat_mode <= 1'b0;
        end else if (ctrl_wr) begin
            sat_mode <= sat_wdata;
        end
    end
endmodule

// File: rtl/rxs_irq.sv
module rxs_irq #(
    parameter int NUM_CNT = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CNT-1:0] rise,
    input  logic [NUM_CNT-1:0] clr,
    input  logic               wipe,
    input  logic [NUM_CNT-1:0] mask,
    output logic [NUM_CNT-1:0] stat,
    output logic               irq
);
    logic [NUM_CNT-1:0] stat_d;

    always_comb begin
        if (wipe) begin
            stat_d = '0;
        end else begin
            stat_d = (stat & ~clr) | rise;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat <= '0;
        end else begin
            stat <= stat_d;
        end
    end

    assign irq = |(stat & ~mask);
endmodule

// File: rtl/rxs_stat_bank.sv
module rxs_stat_bank #(
    parameter int CNT_W    = 32,
    parameter int NUM_CNT  = 13,
    parameter int STAT_LSB = 11,
    parameter int ADDR_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CNT-1:0] ev_strobe,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [3:0]         reg_be,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               irq
);
    import rxs_pkg::*;

    localparam int STAT_MSB = STAT_LSB + NUM_CNT - 1;

    logic [CNT_W-1:0]   cnt_q [NUM_CNT];
    logic [NUM_CNT-1:0] rise;
    logic [NUM_CNT-1:0] clr;
    logic [NUM_CNT-1:0] cnt_sel;
    logic [NUM_CNT-1:0] stat;
    logic [NUM_CNT-1:0] mask_q;
    logic [NUM_CNT-1:0] mask_d;
    logic               wipe;
    logic               sat_mode;
    logic               ctrl_wr;
    logic               mask_wr;
    logic [REG_W-1:0]   stat_word;
    logic [REG_W-1:0]   mask_word;
    logic [REG_W-1:0]   cnt_word;

    assign ctrl_wr = reg_wr && reg_be[0] && (reg_addr == ADDR_W'(ADR_CTRL));
    assign mask_wr = reg_wr && (reg_addr == ADDR_W'(ADR_MASK));

    rxs_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .wipe_req  (reg_wdata[CTRL_WIPE]),
        .sat_wdata (reg_wdata[CTRL_SAT]),
        .wipe      (wipe),
        .sat_mode  (sat_mode)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        assign cnt_sel[i] = (reg_addr == ADDR_W'(ADR_CNT0 + i));
        assign clr[i]     = reg_rd && reg_be[0] && cnt_sel[i];

        rxs_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .inc      (ev_strobe[i]),
            .wipe     (wipe),
            .sat      (sat_mode),
            .q        (cnt_q[i]),
            .msb_rise (rise[i])
        );

        assign mask_d[i] = reg_be[(STAT_LSB + i) / 8] ? reg_wdata[STAT_LSB + i] : mask_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_wr) begin
            mask_q <= mask_d;
        end
    end

    rxs_irq #(.NUM_CNT(NUM_CNT)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .rise  (rise),
        .clr   (clr),
        .wipe  (wipe),
        .mask  (mask_q),
        .stat  (stat),
        .irq   (irq)
    );

    always_comb begin
        stat_word = '0;
        mask_word = '0;
        stat_word[STAT_MSB:STAT_LSB] = stat;
        mask_word[STAT_MSB:STAT_LSB] = mask_q;
    end

    always_comb begin
        cnt_word = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (cnt_sel[i]) begin
                cnt_word = REG_W'(cnt_q[i]);
            end
        end
    end

    always_comb begin
        if (reg_addr == ADDR_W'(ADR_CTRL)) begin
            reg_rdata = REG_W'({sat_mode, wipe});
        end else if (reg_addr == ADDR_W'(ADR_STAT)) begin
            reg_rdata = stat_word;
        end else if (reg_addr == ADDR_W'(ADR_MASK)) begin
            reg_rdata = mask_word;
        end else begin
            reg_rdata = cnt_word;
        end
    end
endmodule

// File: rtl/rxs_stat_bank_chk.sv
module rxs_stat_bank_chk #(
    parameter int CNT_W    = 32,
    parameter int NUM_CNT  = 13,
    parameter int STAT_LSB = 11,
    parameter int ADDR_W   = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_CNT-1:0] ev_strobe,
    input logic               wipe,
    input logic               sat_mode,
    input logic               ctrl_wr,
    input logic               wipe_bit,
    input logic [CNT_W-1:0]   cnt0,
    input logic [31:0]        stat_word,
    input logic [NUM_CNT-1:0] mask_q,
    input logic               irq
);
    localparam logic [CNT_W-1:0] CMAX = '1;
    localparam logic [CNT_W-1:0] HALF_M1 = {1'b0, {(CNT_W-1){1'b1}}};

    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!wipe && ev_strobe[0] && cnt0 != CMAX) |=> (cnt0 == $past(cnt0) + 1'b1));

    a_r2_set_at_half: assert property (@(posedge clk) disable iff (!rst_n)
        (!wipe && ev_strobe[0] && cnt0 == HALF_M1) |=> stat_word[STAT_LSB]);

    a_r5_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wipe && sat_mode && ev_strobe[0] && cnt0 == CMAX) |=> (cnt0 == CMAX));

    a_r6_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!wipe && !sat_mode && ev_strobe[0] && cnt0 == CMAX) |=> (cnt0 == '0));

    a_r7_wipe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |=> (!irq && cnt0 == '0));

    a_r7_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wipe && !(ctrl_wr && wipe_bit)) |=> !wipe);

    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_word[31:24] == 8'h00) && (stat_word[10:0] == 11'h000));

    a_r9_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q) |-> !irq);
endmodule

bind rxs_stat_bank rxs_stat_bank_chk #(
    .CNT_W    (CNT_W),
    .NUM_CNT  (NUM_CNT),
    .STAT_LSB (STAT_LSB),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_strobe (ev_strobe),
    .wipe      (wipe),
    .sat_mode  (sat_mode),
    .ctrl_wr   (ctrl_wr),
    .wipe_bit  (reg_wdata[0]),
    .cnt0      (cnt_q[0]),
    .stat_word (stat_word),
    .mask_q    (mask_q),
    .irq       (irq)
);

// File: tb/rxs_stat_bank_test.sv
module rxs_stat_bank_test;
    localparam int CW = 10;
    localparam int NC = 13;
    localparam int AW = 5;
    localparam int CMAX = (1 << CW) - 1;
    localparam int HALF = 1 << (CW - 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] ev_strobe = '0;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [3:0]    reg_be = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] d;

    always #2.5 clk = ~clk;

    rxs_stat_bank #(.CNT_W(CW), .NUM_CNT(NC), .STAT_LSB(11), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .ev_strobe(ev_strobe), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_be(reg_be), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    // entry: {counter index[3:0], strobes[9:0], expected count[9:0]}
    localparam logic [23:0] VEC [5] = '{
        {4'd0,  10'd3, 10'd3},
        {4'd5,  10'd1, 10'd1},
        {4'd12, 10'd7, 10'd7},
        {4'd0,  10'd2, 10'd5},
        {4'd12, 10'd1, 10'd8}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse(input int idx, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            ev_strobe = '0;
            ev_strobe[idx] = 1'b1;
        end
        @(negedge clk);
        ev_strobe = '0;
    endtask

    task automatic rd(input int a, input logic [3:0] be, output logic [31:0] v);
        @(negedge clk);
        reg_addr = AW'(a); reg_be = be; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(posedge clk);
        #1 reg_rd = 1'b0; reg_be = '0;
    endtask

    task automatic wr(input int a, input logic [3:0] be, input logic [31:0] v);
        @(negedge clk);
        reg_addr = AW'(a); reg_be = be; reg_wdata = v; reg_wr = 1'b1;
        @(posedge clk);
        #1 reg_wr = 1'b0; reg_be = '0; reg_wdata = '0;
    endtask

    function automatic logic [31:0] sbit(input int i);
        return 32'(1) << (11 + i);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R8 R1 reset state
        rd(0, 4'h1, d); chk("R8 ctrl reset", d, 0);
        rd(1, 4'h1, d); chk("R8 status reset", d, 0);
        rd(2, 4'h1, d); chk("R8 mask reset", d, 0);
        chk("R9 irq reset", 32'(irq), 0);
        rd(4 + 7, 4'h2, d); chk("R1 counter reset", d, 0);
        rd(3, 4'h1, d); chk("R10 unused address", d, 0);

        // R1 R10 vector table
        for (int v = 0; v < 5; v++) begin
            pulse(int'(VEC[v][23:20]), int'(VEC[v][19:10]));
            rd(4 + int'(VEC[v][23:20]), 4'h2, d);
            chk("R1 R10 count", d, 32'(VEC[v][9:0]));
        end

        // R2 R3 half-full set and byte-lane clear
        pulse(1, HALF - 1);
        rd(1, 4'h1, d); chk("R2 below half", d, 0);
        pulse(1, 1);
        rd(1, 4'h1, d); chk("R2 at half", d, sbit(1));
        chk("R9 irq raised", 32'(irq), 1);
        rd(4 + 1, 4'h2, d); chk("R3 read value", d, HALF);
        rd(1, 4'h1, d); chk("R3 no clear without lane 0", d, sbit(1));
        rd(4 + 1, 4'h1, d);
        rd(1, 4'h1, d); chk("R3 clear by lane 0", d, 0);

        // R9 masking
        pulse(2, HALF);
        wr(2, 4'h2, sbit(2));
        chk("R9 masked irq", 32'(irq), 0);
        rd(1, 4'h1, d); chk("R9 status kept under mask", d, sbit(2));
        wr(2, 4'hF, 0);
        chk("R9 unmasked irq", 32'(irq), 1);
        rd(4 + 2, 4'h1, d);

        // R4 collision of clearing read and increment
        pulse(6, HALF - 1);
        @(negedge clk);
        ev_strobe[6] = 1'b1; reg_addr = AW'(4 + 6); reg_be = 4'h1; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(posedge clk);
        #1 reg_rd = 1'b0; reg_be = '0; ev_strobe = '0;
        chk("R4 pre-increment data", d, HALF - 1);
        rd(1, 4'h1, d); chk("R4 rise wins over clear", d, sbit(6));
        @(negedge clk);
        ev_strobe[6] = 1'b1; reg_addr = AW'(4 + 6); reg_be = 4'h1; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(posedge clk);
        #1 reg_rd = 1'b0; reg_be = '0; ev_strobe = '0;
        chk("R4 pre-increment data at half", d, HALF);
        rd(1, 4'h1, d); chk("R4 clear without rise", d, 0);
        rd(4 + 6, 4'h2, d); chk("R4 counter after", d, HALF + 1);

        // R7 global wipe
        pulse(9, HALF);
        wr(0, 4'h1, 32'h1);
        @(negedge clk);
        ev_strobe[0] = 1'b1; reg_addr = AW'(0); reg_be = 4'h1; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(posedge clk);
        #1 reg_rd = 1'b0; reg_be = '0; ev_strobe = '0;
        chk("R7 clear bit visible", d & 32'h1, 1);
        rd(0, 4'h1, d); chk("R7 clear bit self-cleared", d, 0);
        rd(4 + 0, 4'h2, d); chk("R7 counter 0 zero, strobe dropped", d, 0);
        rd(4 + 6, 4'h2, d); chk("R7 counter 6 zero", d, 0);
        rd(1, 4'h1, d); chk("R7 status zero", d, 0);
        chk("R7 irq low", 32'(irq), 0);

        // R5 saturation
        wr(0, 4'h1, 32'h2);
        rd(0, 4'h1, d); chk("R5 ctrl readback", d, 2);
        pulse(3, CMAX + 2);
        rd(4 + 3, 4'h2, d); chk("R5 saturated", d, CMAX);

        // R6 wrap
        wr(0, 4'h1, 32'h0);
        pulse(3, 1);
        rd(4 + 3, 4'h2, d); chk("R6 wrapped to zero", d, 0);
        pulse(4, CMAX + 2);
        rd(4 + 4, 4'h2, d); chk("R6 wrapped count", d, 1);
        rd(1, 4'h1, d); chk("R2 R6 status after wrap", d, sbit(3) | sbit(4));

        // R8 R9 write masking
        wr(1, 4'hF, 32'hFFFF_FFFF);
        rd(1, 4'h1, d); chk("R8 status write ignored", d, sbit(3) | sbit(4));
        wr(2, 4'hF, 32'hFFFF_FFFF);
        rd(2, 4'h1, d); chk("R9 mask stored bits", d, 32'h00FF_F800);
        chk("R9 all masked", 32'(irq), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule